// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a processor core and a data memory that is one 32-bit word wide and addressed in bytes. For each access the core gives a byte address, an access size (byte, halfword or word), a flag that selects zero extension instead of sign extension, and the store data. The block turns these into a word address, four byte-lane enables and write data moved onto the right lanes. For loads it picks the addressed bytes out of the returned word, extends them to 32 bits and presents the result one cycle later with a valid strobe.

Lane ordering is big-endian: the byte at offset 0 within a word is the most significant byte. Every access must be aligned to its own size. A misaligned access writes nothing, returns zero as load data and raises a one-cycle error flag. It is never split into two accesses.

Top module: `be_lane_unit`

## Requirements
- R1: `mem_addr` equals `addr` shifted right by two. This is the word address, and consecutive words differ by 4 in byte address.
- R2: Size encoding: 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A reserved size is treated as misaligned.
- R3: A byte store at offset k drives `mem_be` = 4'b1000 >> k. `mem_be[3]` covers bits [31:24], which hold offset 0. The low byte of `wdata` appears on that lane of `mem_wdata`.
- R4: A halfword store drives `mem_be` = 4'b1100 at offset 0 and 4'b0011 at offset 2, with `wdata[15:0]` on those lanes.
- R5: An aligned word store drives `mem_be` = 4'b1111 and passes `wdata` through unchanged.
- R6: A partial store leaves the memory bytes outside its lanes unchanged.
- R7: A signed byte or halfword load sign-extends the selected bytes to 32 bits. For example, byte 0xF7 loads as 0xFFFFFFF7.
- R8: An unsigned byte or halfword load zero-extends the selected bytes. For example, byte 0xF7 loads as 0x000000F7.
- R9: `ld_valid` is high exactly in the cycle after a load request, with `ld_data` valid in that cycle. It stays low after a store or an idle cycle.
- R10: A misaligned access has one of these forms: a halfword at an odd offset, a word at a nonzero offset, or a reserved size. It drives `mem_we` low and `mem_be` to zero. `err` is high for one cycle after the request, and a misaligned load returns zero.
- R11: After reset, `ld_valid`, `err` and `ld_data` are zero. `mem_we` is low whenever `req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request this cycle |
| wr | input | 1 | 1 = store, 0 = load |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| ld_unsigned | input | 1 | Zero-extend byte/halfword loads |
| addr | input | AW | Byte address |
| wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Word returned by memory in the request cycle |
| mem_addr | output | AW-2 | Word address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane enables, bit 3 = most significant lane |
| mem_wdata | output | 32 | Lane-aligned write data |
| ld_data | output | 32 | Extended load result |
| ld_valid | output | 1 | Load result valid |
| err | output | 1 | Misaligned access flag |

## Verification
The loads are tried against a word preloaded with bytes that have mixed top bits (F7, 12, 80, 05). Loading each offset in both signed and unsigned forms separates a wrong lane choice from a wrong extension. Halfword loads at both halves, with values on either side of 0x8000, distinguish big-endian ordering from little-endian ordering. Stores of each size are written into a known background and read back as words, which exposes stray lane enables that touch neighbouring bytes. Misaligned halfword, word and reserved-size cases check that the memory stays untouched, that zero is returned and that the error pulse appears in the right cycle.

// File: rtl/be_lane_unit.sv
module be_lane_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [1:0]    size,
  input  logic          ld_unsigned,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [31:0]   mem_rdata,
  output logic [AW-3:0] mem_addr,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  output logic [31:0]   ld_data,
  output logic          ld_valid,
  output logic          err
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  logic [1:0]  off;
  logic        mis;
  logic [3:0]  be;
  logic [31:0] wd;
  logic [7:0]  bsel;
  logic [15:0] hsel;
  logic [31:0] ext;

  assign off      = addr[1:0];
  assign mem_addr = addr[AW-1:2];

  always_comb begin
    case (size)
      SZ_B:    mis = 1'b0;
      SZ_H:    mis = off[0];
      SZ_W:    mis = |off;
      default: mis = 1'b1;
    endcase
  end

  always_comb begin
    case (size)
      SZ_B: begin
        be = 4'b1000 >> off;
        wd = {4{wdata[7:0]}};
      end
      SZ_H: begin
        be = off[1] ? 4'b0011 : 4'b1100;
        wd = {2{wdata[15:0]}};
      end
      default: begin
        be = 4'b1111;
        wd = wdata;
      end
    endcase
  end

  assign mem_be    = (req && !mis) ? be : 4'b0000;
  assign mem_we    = req && wr && !mis;
  assign mem_wdata = wd;

  always_comb begin
    case (off)
      2'd0:    bsel = mem_rdata[31:24];
      2'd1:    bsel = mem_rdata[23:16];
      2'd2:    bsel = mem_rdata[15:8];
      default: bsel = mem_rdata[7:0];
    endcase
  end

  assign hsel = off[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    case (size)
      SZ_B:    ext = {{24{bsel[7] & ~ld_unsigned}}, bsel};
      SZ_H:    ext = {{16{hsel[15] & ~ld_unsigned}}, hsel};
      default: ext = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      err      <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= req && !wr;
      err      <= req && mis;
      ld_data  <= (req && !wr && !mis) ? ext : 32'h0;
    end
  end
endmodule

module be_lane_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        wr,
  input logic [1:0]  size,
  input logic        ld_unsigned,
  input logic [1:0]  addr_lo,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [31:0] ld_data,
  input logic        ld_valid,
  input logic        err
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!mem_we && mem_be == 4'b0000)); // R11
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && size == 2'd0) |-> $countones(mem_be) == 1); // R3
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req && size == 2'd2 && addr_lo == 2'd0) |-> mem_be == 4'b1111); // R5
  AST_MISALIGN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (size == 2'd3 || (size == 2'd2 && addr_lo != 2'd0) || (size == 2'd1 && addr_lo[0])))
      |-> (!mem_we && mem_be == 4'b0000)); // R10
  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req)); // R10
  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(req && !wr)); // R9
  AST_UNSIGNED_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && ld_unsigned && size == 2'd0) |=> ld_data[31:8] == 24'h0); // R8
  AST_ERR_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && err) |-> ld_data == 32'h0); // R10
endmodule

bind be_lane_unit be_lane_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size(size),
  .ld_unsigned(ld_unsigned), .addr_lo(addr[1:0]), .mem_we(mem_we),
  .mem_be(mem_be), .ld_data(ld_data), .ld_valid(ld_valid), .err(err)
);

// File: tb/tb_be_lane_unit.sv
module tb_be_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  size = 2'd0;
  logic        ld_unsigned = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] mem_rdata;
  logic [29:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] ld_data;
  logic        ld_valid;
  logic        err;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] mem [16];

  always #5 clk = ~clk;

  be_lane_unit #(.AW(32)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size(size),
    .ld_unsigned(ld_unsigned), .addr(addr), .wdata(wdata),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .ld_data(ld_data),
    .ld_valid(ld_valid), .err(err)
  );

  assign mem_rdata = mem[mem_addr[3:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // {addr[7:0], size[1:0], unsigned, err, expected[31:0]}
  localparam int NV = 15;
  localparam logic [43:0] VEC [NV] = '{
    {8'd0, 2'd0, 1'b0, 1'b0, 32'hFFFFFFF7},
    {8'd0, 2'd0, 1'b1, 1'b0, 32'h000000F7},
    {8'd1, 2'd0, 1'b0, 1'b0, 32'h00000012},
    {8'd2, 2'd0, 1'b0, 1'b0, 32'hFFFFFF80},
    {8'd2, 2'd0, 1'b1, 1'b0, 32'h00000080},
    {8'd3, 2'd0, 1'b1, 1'b0, 32'h00000005},
    {8'd0, 2'd1, 1'b0, 1'b0, 32'hFFFFF712},
    {8'd2, 2'd1, 1'b1, 1'b0, 32'h00008005},
    {8'd2, 2'd1, 1'b0, 1'b0, 32'hFFFF8005},
    {8'd4, 2'd2, 1'b0, 1'b0, 32'h7FFF8001},
    {8'd4, 2'd1, 1'b0, 1'b0, 32'h00007FFF},
    {8'd6, 2'd1, 1'b0, 1'b0, 32'hFFFF8001},
    {8'd1, 2'd1, 1'b0, 1'b1, 32'h00000000},
    {8'd6, 2'd2, 1'b0, 1'b1, 32'h00000000},
    {8'd4, 2'd3, 1'b0, 1'b1, 32'h00000000}
  };

  task automatic load(input logic [31:0] a, input logic [1:0] sz, input logic u);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = a; size = sz; ld_unsigned = u;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic store_drive(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a; size = sz; wdata = d;
  endtask

  task automatic store_end();
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem[0] = 32'hF7128005;
    mem[1] = 32'h7FFF8001;
    mem[2] = 32'hAABBCCDD;
    repeat (3) @(negedge clk);
    check("R11 reset ld_valid", {31'h0, ld_valid}, 32'h0);
    check("R11 reset err", {31'h0, err}, 32'h0);
    check("R11 reset ld_data", ld_data, 32'h0);
    check("R11 idle mem_we", {31'h0, mem_we}, 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      load({24'h0, VEC[v][43:36]}, VEC[v][35:34], VEC[v][33]);
      check($sformatf("R7/R8 vec%0d ld_data", v), ld_data, VEC[v][31:0]);
      check($sformatf("R9 vec%0d ld_valid", v), {31'h0, ld_valid}, 32'h1);
      check($sformatf("R10 vec%0d err", v), {31'h0, err}, {31'h0, VEC[v][32]});
    end
    @(negedge clk);
    check("R10 err one cycle", {31'h0, err}, 32'h0);
    check("R9 ld_valid drops", {31'h0, ld_valid}, 32'h0);

    addr = 32'h0000_0024; req = 1'b1; wr = 1'b0; size = 2'd0;
    #1 check("R1 word address", {2'b0, mem_addr}, 32'h9);
    req = 1'b0;

    store_drive(32'd9, 2'd0, 32'h12345611);
    #1 check("R3 byte be off1", {28'h0, mem_be}, 32'h4);
    check("R3 byte lane data", {24'h0, mem_wdata[23:16]}, 32'h11);
    store_end();
    check("R9 no valid after store", {31'h0, ld_valid}, 32'h0);
    load(32'd8, 2'd2, 1'b0);
    check("R6 byte store keeps others", ld_data, 32'hAA11CCDD);

    store_drive(32'd11, 2'd0, 32'h000000EE);
    #1 check("R3 byte be off3", {28'h0, mem_be}, 32'h1);
    store_end();
    load(32'd8, 2'd2, 1'b0);
    check("R6 byte store off3", ld_data, 32'hAA11CCEE);

    store_drive(32'd10, 2'd1, 32'hFFFF9876);
    #1 check("R4 half be off2", {28'h0, mem_be}, 32'h3);
    store_end();
    load(32'd8, 2'd2, 1'b0);
    check("R6 half store keeps top", ld_data, 32'hAA119876);

    store_drive(32'd8, 2'd1, 32'h00004321);
    #1 check("R4 half be off0", {28'h0, mem_be}, 32'hC);
    store_end();
    load(32'd8, 2'd2, 1'b0);
    check("R4 half store top", ld_data, 32'h43219876);

    store_drive(32'd9, 2'd1, 32'h0000BEEF);
    #1 check("R10 misaligned be", {28'h0, mem_be}, 32'h0);
    check("R10 misaligned we", {31'h0, mem_we}, 32'h0);
    store_end();
    check("R10 store err pulse", {31'h0, err}, 32'h1);
    load(32'd8, 2'd2, 1'b0);
    check("R10 memory untouched", ld_data, 32'h43219876);

    store_drive(32'd8, 2'd2, 32'hCAFEF00D);
    #1 check("R5 word be", {28'h0, mem_be}, 32'hF);
    check("R5 word data", mem_wdata, 32'hCAFEF00D);
    store_end();
    load(32'd8, 2'd2, 1'b0);
    check("R5 word readback", ld_data, 32'hCAFEF00D);

    store_drive(32'd14, 2'd3, 32'h11111111);
    #1 check("R2 reserved size blocked", {27'h0, mem_we, mem_be}, 32'h0);
    store_end();
    check("R2 reserved size err", {31'h0, err}, 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule